// File: doc/BRIEF.md
# Leaf Page Entry Access Check and Reference/Change Updater

This block is handed one leaf entry of a page table, together with the address the entry was read from, the kind of access being attempted (read, write or instruction fetch), the problem-state flag of the requester and the key-0 fields of the data and instruction authority mask registers. It decides whether the access may go ahead and, if so, which read, write and execute rights may be cached for the page. When the access is refused it reports a cause vector.

When the access is allowed, the block sets the reference bit of the entry, and the change bit for a write. It writes the updated entry back to memory through a 64-bit write port with a request/acknowledge handshake, but only when the updated entry differs from the one supplied. Write permission is granted only to a write access. After a read or fetch, a later store must come back through the block so that the change bit gets set. The block handles one request at a time. A start pulse captures all inputs, and a one-cycle done pulse marks the moment the results on the outputs are valid.

Top module: `pte_rights_unit`

## Requirements
- R1: After reset, `done` and `memWrReq` are low.
- R2: Entry bits 5:4 hold a 2-bit attribute code. The codes 0, 1, 2 and 3 expand to 0x2, 0xE, 0x7 and 0x6. When bit 0 of the expanded value is set (only code 2), a fetch (`accessKind` = 2) faults with `cause` bit 0 (guarded fetch) set, whatever the rights. Reads and writes are not affected by this check.
- R3: Entry bits 3:0 are, from the top: privileged-only, read, read-write and execute. The read-write bit grants both read and write. `grant` bit 0 is read, bit 1 is write and bit 2 is execute.
- R4: On a privileged-only page accessed in problem state, the rights are empty, so every access faults with `cause` bit 1.
- R5: In privileged state on a page that is not privileged-only, the rights are masked. `amrKey[1]` removes write, `amrKey[0]` removes read and `iamrKey[0]` removes execute. The mask is not applied in problem state or on a privileged-only page.
- R6: When the right the access needs (read for `accessKind` 0 or 3, write for 1, execute for 2) is missing, the access faults with `cause` bit 1 (protection). On any fault, `grant` is zero and no write-back is issued.
- R7: A fault raised for a write access also sets `cause` bit 2 (store). On a fetch or read fault, bit 2 is clear.
- R8: On an allowed access, the updated entry is the original with bit 8 (reference) set, and with bit 7 (change) set as well for a write. It is written to `entryAddr` only when it differs from the original.
- R9: On an allowed read or fetch, write is removed from `grant`. On an allowed write, `grant` is the full set of rights.
- R10: `memWrReq`, `memWrAddr` and `memWrData` stay steady until `memWrAck` is sampled high. `done` pulses for one cycle, in the cycle after the acknowledge. When no write-back is needed, `done` pulses two cycles after the start edge.
- R11: A `start` pulse that arrives while a request is in progress is ignored. It produces no extra `done` pulse and does not alter the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the inputs and begin a check |
| entryIn | input | ENTRY_W | Leaf page table entry |
| entryAddr | input | ADDR_W | Memory address the entry came from |
| accessKind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| probState | input | 1 | Requester is in problem (user) state |
| amrKey | input | 2 | Key-0 field of the data authority mask |
| iamrKey | input | 2 | Key-0 field of the instruction authority mask |
| done | output | 1 | One-cycle pulse: results valid |
| fault | output | 1 | Access refused |
| cause | output | 3 | Bit 0 guarded fetch, bit 1 protection, bit 2 store |
| grant | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| memWrReq | output | 1 | Write-back request |
| memWrAddr | output | ADDR_W | Write-back address |
| memWrData | output | ENTRY_W | Updated entry |
| memWrAck | input | 1 | Write-back accepted |

## Verification
The hardest states to reach from the ports are an outstanding write-back that is held for several cycles, and a second start that arrives during that wait. The stimulus holds the acknowledge back by a chosen number of cycles. Meanwhile it checks that `done` stays low and that the request data does not move. In one case it pulses `start` with a different entry while the write is pending. The other hard case is a suppressed write-back, which occurs only when the entry already carries the reference bit, and the change bit too for a write. The stimulus supplies such entries and checks the two-cycle latency with the write port idle.

// File: rtl/pte_rights_pkg.sv
package pte_rights_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic issueWrite;
  } ctrlStrobe_t;

  // entry field positions (decoded by the memory image, so fixed)
  localparam int REF_BIT   = 8;
  localparam int CHG_BIT   = 7;
  localparam int ATTR_HI   = 5;
  localparam int ATTR_LO   = 4;
  localparam int PRIV_BIT  = 3;
  localparam int RD_BIT    = 2;
  localparam int RW_BIT    = 1;
  localparam int EX_BIT    = 0;

  // cause vector layout
  localparam int CAUSE_W     = 3;
  localparam int CAUSE_GUARD = 0;
  localparam int CAUSE_PROT  = 1;
  localparam int CAUSE_STORE = 2;

  // grant layout
  localparam int GRANT_W = 3;
  localparam int G_RD    = 0;
  localparam int G_WR    = 1;
  localparam int G_EX    = 2;

  // attribute code expansion; bit 0 of the expanded value marks guarded storage
  function automatic logic attrGuarded(input logic [1:0] code);
    logic [3:0] expanded;
    case (code)
      2'd0:    expanded = 4'h2;
      2'd1:    expanded = 4'hE;
      2'd2:    expanded = 4'h7;
      default: expanded = 4'h6;
    endcase
    return expanded[0];
  endfunction

endpackage

// File: rtl/pte_rights_dp.sv
module pte_rights_dp
  import pte_rights_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int ADDR_W  = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [ENTRY_W-1:0]  entryIn,
  input  logic [ADDR_W-1:0]   entryAddr,
  input  logic [1:0]          accessKind,
  input  logic                probState,
  input  logic [1:0]          amrKey,
  input  logic [1:0]          iamrKey,
  input  logic                memWrAck,
  output logic                needWrite,
  output logic                fault,
  output logic [CAUSE_W-1:0]  cause,
  output logic [GRANT_W-1:0]  grant,
  output logic                memWrReq,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [ENTRY_W-1:0]  memWrData
);

  localparam logic [ENTRY_W-1:0] REF_MASK = ENTRY_W'(1) << REF_BIT;
  localparam logic [ENTRY_W-1:0] CHG_MASK = ENTRY_W'(1) << CHG_BIT;

  logic [ENTRY_W-1:0] capEntry;
  logic [ADDR_W-1:0]  capAddr;
  accKind_t           capAcc;
  logic               capProb;
  logic [1:0]         capAmr;
  logic               capIamr;
  logic               unusedIamrHi;

  assign unusedIamrHi = iamrKey[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capEntry <= '0;
      capAddr  <= '0;
      capAcc   <= ACC_READ;
      capProb  <= 1'b0;
      capAmr   <= 2'b00;
      capIamr  <= 1'b0;
    end else if (strobe.capture) begin
      capEntry <= entryIn;
      capAddr  <= entryAddr;
      capAcc   <= accKind_t'(accessKind);
      capProb  <= probState;
      capAmr   <= amrKey;
      capIamr  <= iamrKey[0];
    end
  end

  // rights evaluation
  logic               isWrite;
  logic               isExec;
  logic               pagePriv;
  logic               guardedHit;
  logic [GRANT_W-1:0] baseRights;
  logic [GRANT_W-1:0] keyMask;
  logic [GRANT_W-1:0] effRights;
  logic [GRANT_W-1:0] needRight;
  logic               protHit;
  logic [ENTRY_W-1:0] newEntry;

  assign isWrite  = (capAcc == ACC_WRITE);
  assign isExec   = (capAcc == ACC_EXEC);
  assign pagePriv = capEntry[PRIV_BIT];

  always_comb begin
    baseRights       = '0;
    baseRights[G_RD] = capEntry[RD_BIT] | capEntry[RW_BIT];
    baseRights[G_WR] = capEntry[RW_BIT];
    baseRights[G_EX] = capEntry[EX_BIT];

    keyMask       = '1;
    keyMask[G_RD] = ~capAmr[0];
    keyMask[G_WR] = ~capAmr[1];
    keyMask[G_EX] = ~capIamr;

    if (pagePriv && capProb)       effRights = '0;
    else if (pagePriv || capProb)  effRights = baseRights;
    else                           effRights = baseRights & keyMask;
  end

  always_comb begin
    needRight = '0;
    case (capAcc)
      ACC_WRITE: needRight[G_WR] = 1'b1;
      ACC_EXEC:  needRight[G_EX] = 1'b1;
      default:   needRight[G_RD] = 1'b1;
    endcase
  end

  assign guardedHit = isExec && attrGuarded(capEntry[ATTR_HI:ATTR_LO]);
  assign protHit    = !guardedHit && ((needRight & effRights) == '0);
  assign fault      = guardedHit || protHit;

  always_comb begin
    cause = '0;
    cause[CAUSE_GUARD] = guardedHit;
    cause[CAUSE_PROT]  = protHit;
    cause[CAUSE_STORE] = protHit && isWrite;
  end

  always_comb begin
    grant = effRights;
    if (!isWrite) grant[G_WR] = 1'b0;
    if (fault)    grant = '0;
  end

  assign newEntry  = capEntry | REF_MASK | (isWrite ? CHG_MASK : '0);
  assign needWrite = !fault && (newEntry != capEntry);

  assign memWrReq  = strobe.issueWrite;
  assign memWrAddr = capAddr;
  assign memWrData = newEntry;

  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && !memWrAck |=> memWrReq && $stable(memWrData) && $stable(memWrAddr)); // R10
  AST_WR_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> !fault && grant != '0); // R6
  AST_WR_REF_SET: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> memWrData[REF_BIT]); // R8
  AST_WGRANT_ONLY_STORE: assert property (@(posedge clk) disable iff (!rstN)
    grant[G_WR] |-> capAcc == ACC_WRITE); // R9
  AST_PRIV_USER_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    pagePriv && capProb |-> grant == '0 && fault); // R4

endmodule

// File: rtl/pte_rights_ctrl.sv
module pte_rights_ctrl
  import pte_rights_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        needWrite,
  input  logic        memWrAck,
  output ctrlStrobe_t strobe,
  output logic        done
);

  ctrlState_t state;
  ctrlState_t nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:  if (start) nextState = ST_EVAL;
      ST_EVAL:  nextState = needWrite ? ST_WRITE : ST_DONE;
      ST_WRITE: if (memWrAck) nextState = ST_DONE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe            = '0;
    strobe.capture    = (state == ST_IDLE) && start;
    strobe.issueWrite = (state == ST_WRITE);
  end

  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_ACK_TO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueWrite && memWrAck |=> done && !strobe.issueWrite); // R10
  AST_NO_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture); // R11

endmodule

// File: rtl/pte_rights_unit.sv
module pte_rights_unit
  import pte_rights_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int ADDR_W  = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [ENTRY_W-1:0]  entryIn,
  input  logic [ADDR_W-1:0]   entryAddr,
  input  logic [1:0]          accessKind,
  input  logic                probState,
  input  logic [1:0]          amrKey,
  input  logic [1:0]          iamrKey,
  output logic                done,
  output logic                fault,
  output logic [2:0]          cause,
  output logic [2:0]          grant,
  output logic                memWrReq,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [ENTRY_W-1:0]  memWrData,
  input  logic                memWrAck
);

  ctrlStrobe_t strobe;
  logic        needWrite;

  pte_rights_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .needWrite (needWrite),
    .memWrAck  (memWrAck),
    .strobe    (strobe),
    .done      (done)
  );

  pte_rights_dp #(
    .ENTRY_W (ENTRY_W),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .entryIn    (entryIn),
    .entryAddr  (entryAddr),
    .accessKind (accessKind),
    .probState  (probState),
    .amrKey     (amrKey),
    .iamrKey    (iamrKey),
    .memWrAck   (memWrAck),
    .needWrite  (needWrite),
    .fault      (fault),
    .cause      (cause),
    .grant      (grant),
    .memWrReq   (memWrReq),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !done && !memWrReq); // R1
  AST_NO_DONE_WHILE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> !done); // R10

endmodule

// File: tb/pte_rights_unit_bench.sv
`timescale 1ns/1ps
module pte_rights_unit_bench;

  localparam int AW = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] entryIn = '0;
  logic [AW-1:0] entryAddr = '0;
  logic [1:0]  accessKind = '0;
  logic        probState = 1'b0;
  logic [1:0]  amrKey = '0;
  logic [1:0]  iamrKey = '0;
  logic        done;
  logic        fault;
  logic [2:0]  cause;
  logic [2:0]  grant;
  logic        memWrReq;
  logic [AW-1:0] memWrAddr;
  logic [63:0] memWrData;
  logic        memWrAck = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pte_rights_unit #(.ENTRY_W(64), .ADDR_W(AW)) u_pte_rights_unit (
    .clk(clk), .rstN(rstN), .start(start), .entryIn(entryIn), .entryAddr(entryAddr),
    .accessKind(accessKind), .probState(probState), .amrKey(amrKey), .iamrKey(iamrKey),
    .done(done), .fault(fault), .cause(cause), .grant(grant), .memWrReq(memWrReq),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrAck(memWrAck)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirement text
  task automatic model(input logic [63:0] e, input logic [1:0] acc, input logic prob,
                       input logic [1:0] amr, input logic [1:0] iamr,
                       output logic f, output logic [2:0] c, output logic [2:0] g,
                       output logic w, output logic [63:0] nd);
    logic [2:0] rights;
    logic [2:0] need;
    logic       guarded;
    guarded = (e[5:4] == 2'd2);
    rights  = {e[0], e[1], e[2] | e[1]};
    if (e[3] && prob) rights = 3'b000;
    else if (!e[3] && !prob) rights = rights & {~iamr[0], ~amr[1], ~amr[0]};
    need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b001;
    f = 1'b0; c = 3'b000;
    if (acc == 2'd2 && guarded) begin f = 1'b1; c = 3'b001; end
    else if ((rights & need) == 3'b000) begin f = 1'b1; c = (acc == 2'd1) ? 3'b110 : 3'b010; end
    g  = f ? 3'b000 : ((acc == 2'd1) ? rights : (rights & 3'b101));
    nd = e | 64'h100 | ((acc == 2'd1) ? 64'h80 : 64'h0);
    w  = !f && (nd != e);
  endtask

  task automatic runCase(input string req, input logic [63:0] e, input logic [AW-1:0] addr,
                         input logic [1:0] acc, input logic prob, input logic [1:0] amr,
                         input logic [1:0] iamr, input int ackDelay, input bit pokeBusy);
    logic f; logic [2:0] c; logic [2:0] g; logic w; logic [63:0] nd;
    bit gotWr = 0; bit ackGiven = 0; bit poked = 0;
    int waitCnt = 0; int doneAt = 0;
    logic [63:0] firstData = '0; logic [AW-1:0] firstAddr = '0;
    model(e, acc, prob, amr, iamr, f, c, g, w, nd);
    @(negedge clk);
    entryIn = e; entryAddr = addr; accessKind = acc; probState = prob;
    amrKey = amr; iamrKey = iamr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      memWrAck = 1'b0;
      start = 1'b0;
      if (done) begin doneAt = k; break; end
      if (memWrReq) begin
        if (!gotWr) begin firstData = memWrData; firstAddr = memWrAddr; end
        else chk(memWrData == firstData && memWrAddr == firstAddr, "R10", "request stable",
                 memWrData, firstData);
        gotWr = 1;
        if (pokeBusy && !poked) begin
          poked = 1; start = 1'b1; entryIn = 64'h0; accessKind = 2'd2;
        end
        if (!ackGiven && waitCnt >= ackDelay) begin memWrAck = 1'b1; ackGiven = 1; end
        waitCnt++;
      end
    end
    chk(doneAt != 0, req, "done seen", 64'(doneAt), 64'd1);
    chk(fault == f, req, "fault", 64'(fault), 64'(f));
    chk(cause == c, req, "cause", 64'(cause), 64'(c));
    chk(grant == g, req, "grant", 64'(grant), 64'(g));
    chk(gotWr == w, "R8", "write-back issued", 64'(gotWr), 64'(w));
    if (w) begin
      chk(firstData == nd, "R8", "write data", firstData, nd);
      chk(firstAddr == addr, "R8", "write address", 64'(firstAddr), 64'(addr));
      chk(ackGiven && doneAt == ackDelay + 2, "R10", "done after ack", 64'(doneAt),
          64'(ackDelay + 2));
    end else begin
      chk(doneAt == 1, "R10", "no-write latency", 64'(doneAt), 64'd1);
    end
    @(negedge clk);
    chk(!done, "R10", "done single pulse", 64'(done), 64'd0);
    if (pokeBusy) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!done && !memWrReq, "R11", "no extra activity", 64'({done, memWrReq}), 64'd0);
      end
    end
  endtask

  task automatic testReset();
    chk(!done && !memWrReq, "R1", "reset outputs", 64'({done, memWrReq}), 64'd0);
  endtask

  task automatic testGuarded();
    runCase("R2", 64'h21, 48'h1000, 2'd2, 1'b0, 2'b00, 2'b00, 0, 0); // code 2 fetch
    runCase("R2", 64'h11, 48'h1008, 2'd2, 1'b0, 2'b00, 2'b00, 0, 0); // code 1 fetch ok
    runCase("R2", 64'h24, 48'h1010, 2'd0, 1'b1, 2'b00, 2'b00, 1, 0); // code 2 read ok
  endtask

  task automatic testEncoding();
    runCase("R3", 64'h4, 48'h2000, 2'd0, 1'b1, 2'b00, 2'b00, 0, 0);
    runCase("R3", 64'h2, 48'h2008, 2'd1, 1'b0, 2'b00, 2'b00, 3, 0);
    runCase("R3", 64'h1, 48'h2010, 2'd2, 1'b1, 2'b00, 2'b00, 0, 0);
  endtask

  task automatic testPrivPage();
    runCase("R4", 64'hE, 48'h3000, 2'd0, 1'b1, 2'b00, 2'b00, 0, 0);
    runCase("R4", 64'hF, 48'h3008, 2'd0, 1'b0, 2'b11, 2'b11, 0, 0); // mask skipped R5
  endtask

  task automatic testKeyMask();
    runCase("R5", 64'h7, 48'h4000, 2'd1, 1'b0, 2'b10, 2'b00, 0, 0);
    runCase("R5", 64'h7, 48'h4008, 2'd0, 1'b0, 2'b01, 2'b00, 0, 0);
    runCase("R5", 64'h7, 48'h4010, 2'd2, 1'b0, 2'b00, 2'b01, 0, 0);
    runCase("R5", 64'h7, 48'h4018, 2'd0, 1'b1, 2'b11, 2'b11, 0, 0);
  endtask

  task automatic testProtection();
    runCase("R6", 64'h4, 48'h5000, 2'd2, 1'b1, 2'b00, 2'b00, 0, 0);
    runCase("R7", 64'h4, 48'h5008, 2'd1, 1'b1, 2'b00, 2'b00, 0, 0);
  endtask

  task automatic testNoChange();
    runCase("R8", 64'h104, 48'h6000, 2'd0, 1'b1, 2'b00, 2'b00, 0, 0);
    runCase("R8", 64'h186, 48'h6008, 2'd1, 1'b0, 2'b00, 2'b00, 0, 0);
    runCase("R8", 64'h106, 48'h6010, 2'd1, 1'b0, 2'b00, 2'b00, 2, 0);
  endtask

  task automatic testWriteWithheld();
    runCase("R9", 64'h3, 48'h7000, 2'd0, 1'b0, 2'b00, 2'b00, 1, 0);
    runCase("R9", 64'h3, 48'h7008, 2'd2, 1'b0, 2'b00, 2'b00, 0, 0);
  endtask

  task automatic testBusyStart();
    runCase("R11", 64'h2, 48'h8000, 2'd1, 1'b1, 2'b00, 2'b00, 4, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGuarded();
    testEncoding();
    testPrivPage();
    testKeyMask();
    testProtection();
    testNoChange();
    testWriteWithheld();
    testBusyStart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule